// File: doc/BRIEF.md
# Dual-Channel Tick Compare Timer

This block keeps a free-running system tick counter and watches it with two compare channels. One channel serves the supervisor and the other the hypervisor. Each channel holds a compare word that is one bit wider than the counter. The top bit of that word is a disable flag. The bits below it are the value the counter must reach.

When the counter reaches the value of an enabled, armed channel, the channel sends a one-cycle request to its own sink. The supervisor channel asks for bit 16 of the soft-interrupt register to be set. The hypervisor channel asks for the hypervisor interrupt-pending register to be set to 1. Neither register is part of this block.

A channel is armed when its compare word is written with a value that lies strictly ahead of the counter. It is re-armed each time the counter wraps. While the thread is halted, a hypervisor match is consumed without a request. The counter advances by one on each cycle in which the tick enable is high.

Top module: `tick_match_timer`

## Requirements
- R1: After reset the counter reads 0, and both compare words read back with only the disable bit (the top bit) set. No request is raised.
- R2: The counter increments by one on each clock in which `tick_en` is high, holds when it is low, and wraps from all ones to 0.
- R3: A write with `wr_sel`=0 loads the supervisor compare word and `wr_sel`=1 loads the hypervisor word, all bits included. `rd_data` returns the supervisor word when `rd_sel`=0 and the hypervisor word when `rd_sel`=1.
- R4: While the top bit of a compare word is 1, that channel raises no request. A write with the top bit set cancels a match that is already armed.
- R5: A write arms its channel only if the low bits are strictly greater than the counter value in the write cycle. A value equal to the counter, or behind it, gives its first match only after the counter wraps.
- R6: A match happens when the counter register equals the low compare bits on an armed channel. The request (`soft_tick_req` for the supervisor, `hyp_intp_set` for the hypervisor) is high for exactly the one cycle after that clock. It is therefore seen d+1 ticks after a write made d ticks ahead of the counter.
- R7: A hypervisor match that occurs while `thread_halted` is high gives no request and disarms the channel until the next wrap. The supervisor channel does not look at `thread_halted`.
- R8: A write to a channel in the cycle of its match takes priority. No request comes from the old value, and the new value decides whether the channel is armed.
- R9: An enabled channel whose value has been passed is re-armed at each counter wrap, so it fires at most once per counter lap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Advance the counter this cycle |
| thread_halted | input | 1 | Thread is halted; hypervisor matches are dropped |
| wr_en | input | 1 | Write a compare word |
| wr_sel | input | 1 | Channel to write: 0 supervisor, 1 hypervisor |
| wr_data | input | CNT_W+1 | Compare word: top bit disable, low bits value |
| rd_sel | input | 1 | Channel to read: 0 supervisor, 1 hypervisor |
| rd_data | output | CNT_W+1 | Selected compare word |
| count | output | CNT_W | Current counter value |
| soft_tick_req | output | 1 | One-cycle request to set soft-interrupt bit 16 |
| hyp_intp_set | output | 1 | One-cycle request to set the hypervisor pending register |

## Verification
Two events can land on the same clock: a compare write and the match of the value being replaced. A counter wrap can also coincide with the match of the top counter value. The bench provokes the first case by writing a new value in exactly the cycle the counter sits on the old one. It then checks that no request follows that edge and that the request appears only when the new value is reached. The second case comes up in the full sweep of start and compare values on a 4-bit counter, where every value at or behind the counter has to give exactly one request, at the tick computed from its distance around the wrap.

// File: rtl/tmt_pkg.sv
package tmt_pkg;
   localparam int NUM_CH  = 2;
   localparam int CH_SUP  = 0;
   localparam int CH_HYP  = 1;

   // reset image of a compare word: disabled, value zero
   function automatic logic [63:0] disabled_word(input int width);
      logic [63:0] w;
      w = '0;
      w[width-1] = 1'b1;
      return w;
   endfunction
endpackage

// File: rtl/tmt_counter.sv
module tmt_counter #(
   parameter int CNT_W = 63
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   assign wrap = tick_en & (&cnt);

   always_ff @(posedge clk) begin
      if (!rst_n) cnt <= '0;
      else if (tick_en) cnt <= cnt + ONE;
   end

   a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
      $past(tick_en) && $past(rst_n) |-> cnt == $past(cnt) + ONE);
   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(tick_en) && $past(rst_n) |-> $stable(cnt));
endmodule

// File: rtl/tmt_channel.sv
module tmt_channel #(
   parameter int CNT_W      = 63,
   parameter bit HALT_MASKS = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt,
   input  logic             wrap,
   input  logic             halted,
   input  logic             wr,
   input  logic [CNT_W:0]   wdata,
   output logic [CNT_W:0]   word_q,
   output logic             fire_q
);
   localparam int DIS = CNT_W;
   localparam logic [63:0] RST64 = tmt_pkg::disabled_word(CNT_W + 1);
   localparam logic [CNT_W:0] RST_WORD = RST64[CNT_W:0];

   logic armed;
   logic eq;
   logic hit;
   logic blocked;

   assign eq  = (cnt == word_q[CNT_W-1:0]);
   assign hit = armed & eq & ~wr;

   generate
      if (HALT_MASKS) begin : g_mask
         assign blocked = halted;
      end else begin : g_nomask
         assign blocked = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_q <= RST_WORD;
         armed  <= 1'b0;
         fire_q <= 1'b0;
      end else begin
         fire_q <= hit & ~blocked;
         if (wr) begin
            word_q <= wdata;
            armed  <= ~wdata[DIS] & (wdata[CNT_W-1:0] > cnt);
         end else if (wrap) begin
            armed  <= ~word_q[DIS];
         end else if (hit) begin
            armed  <= 1'b0;
         end
      end
   end

   // R6: a request never lasts beyond one cycle
   a_r6_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      fire_q |=> !fire_q);
   // R6: a request follows a cycle whose counter equalled the value
   a_r6_on_value: assert property (@(posedge clk) disable iff (!rst_n)
      fire_q |-> $past(cnt) == word_q[CNT_W-1:0]);
   // R4: disabled channel is silent
   a_r4_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      fire_q |-> !word_q[DIS]);
   // R4: disabling write leaves the channel disarmed
   a_r4_cancel: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(wr) && $past(wdata[DIS]) |-> !armed);
   // R8: no request from the value replaced in a write cycle
   a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(wr) |-> !fire_q);

   generate
      if (HALT_MASKS) begin : g_halt_chk
         // R7: no hypervisor request out of a halted cycle
         a_r7_halted: assert property (@(posedge clk) disable iff (!rst_n)
            fire_q |-> !$past(halted));
      end
   endgenerate
endmodule

// File: rtl/tick_match_timer.sv
module tick_match_timer #(
   parameter int CNT_W = 63,
   parameter int CMP_W = CNT_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             thread_halted,
   input  logic             wr_en,
   input  logic             wr_sel,
   input  logic [CMP_W-1:0] wr_data,
   input  logic             rd_sel,
   output logic [CMP_W-1:0] rd_data,
   output logic [CNT_W-1:0] count,
   output logic             soft_tick_req,
   output logic             hyp_intp_set
);
   import tmt_pkg::*;

   generate
      if (CNT_W < 2 || CNT_W > 63) begin : g_bad_width
         $error("tick_match_timer: CNT_W must lie in 2..63");
      end
      if (CMP_W != CNT_W + 1) begin : g_bad_cmp
         $error("tick_match_timer: CMP_W must be CNT_W+1");
      end
   endgenerate

   logic             wrap;
   logic [CMP_W-1:0] words [NUM_CH];
   logic [NUM_CH-1:0] fires;

   tmt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
      .cnt(count), .wrap(wrap)
   );

   generate
      for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
         tmt_channel #(
            .CNT_W(CNT_W),
            .HALT_MASKS(ch == CH_HYP)
         ) u_chan (
            .clk(clk), .rst_n(rst_n), .cnt(count), .wrap(wrap),
            .halted(thread_halted),
            .wr(wr_en && (wr_sel == 1'(ch))),
            .wdata(wr_data),
            .word_q(words[ch]),
            .fire_q(fires[ch])
         );
      end
   endgenerate

   assign rd_data       = rd_sel ? words[CH_HYP] : words[CH_SUP];
   assign soft_tick_req = fires[CH_SUP];
   assign hyp_intp_set  = fires[CH_HYP];

   // R1: nothing is requested in the first cycle after reset
   a_r1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> !soft_tick_req && !hyp_intp_set);
endmodule

// File: tb/sim_tick_match_timer.sv
module sim_tick_match_timer;
   localparam int W  = 4;
   localparam int CW = W + 1;
   localparam int LAP = 1 << W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick_en = 1'b0, thread_halted = 1'b0;
   logic wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
   logic [CW-1:0] wr_data = '0;
   logic [CW-1:0] rd_data;
   logic [W-1:0]  count;
   logic soft_tick_req, hyp_intp_set;

   int checks = 0, errors = 0, cycles = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   tick_match_timer #(.CNT_W(W)) u0 (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
      .thread_halted(thread_halted), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
      .count(count), .soft_tick_req(soft_tick_req),
      .hyp_intp_set(hyp_intp_set)
   );

   task automatic check(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic pulse(input int ch);
      return (ch == 0) ? soft_tick_req : hyp_intp_set;
   endfunction

   task automatic do_reset();
      rst_n = 1'b0; tick_en = 1'b0; wr_en = 1'b0; thread_halted = 1'b0;
      @(posedge clk); @(posedge clk); @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         tick_en = 1'b1;
         @(posedge clk); @(negedge clk);
      end
      tick_en = 1'b0;
   endtask

   task automatic write(input int ch, input logic [CW-1:0] d);
      wr_en = 1'b1; wr_sel = 1'(ch); wr_data = d;
      @(posedge clk); @(negedge clk);
      wr_en = 1'b0;
   endtask

   // tick n times, return number of pulses and last position seen
   task automatic watch(input int ch, input int n, output int np, output int pos);
      np = 0; pos = 0;
      for (int i = 1; i <= n; i++) begin
         tick_en = 1'b1;
         @(posedge clk); @(negedge clk);
         if (pulse(ch)) begin np++; pos = i; end
      end
      tick_en = 1'b0;
   endtask

   initial begin
      int np, pos;
      @(negedge clk);
      do_reset();
      // R1
      check("R1 count", count, 0);
      rd_sel = 0; #1 check("R1 sup word", rd_data, 16);
      rd_sel = 1; #1 check("R1 hyp word", rd_data, 16);
      check("R1 no req", {soft_tick_req, hyp_intp_set}, 0);
      // R2
      ticks(20);
      check("R2 wrap count", count, 20 % LAP);
      @(posedge clk); @(posedge clk); @(negedge clk);
      check("R2 hold", count, 20 % LAP);
      // R3
      write(0, 5'h13); write(1, 5'h0C);
      rd_sel = 0; #1 check("R3 sup read", rd_data, 5'h13);
      rd_sel = 1; #1 check("R3 hyp read", rd_data, 5'h0C);

      // R5 R6 R9: full sweep of start and value per channel
      for (int ch = 0; ch < 2; ch++)
         for (int c = 0; c < LAP; c++)
            for (int v = 0; v < LAP; v++) begin
               int d;
               do_reset();
               ticks(c);
               write(ch, CW'(v));
               d = (v - c + LAP) % LAP;
               if (d == 0) d = LAP;
               watch(ch, LAP + 1, np, pos);
               check($sformatf("R5/R6 ch%0d c%0d v%0d position", ch, c, v), pos, d + 1);
               check($sformatf("R9 ch%0d c%0d v%0d count", ch, c, v), np, 1);
            end

      // R4: disabled values never fire
      for (int ch = 0; ch < 2; ch++)
         for (int v = 0; v < LAP; v++) begin
            do_reset();
            write(ch, CW'(v) | CW'(16));
            watch(ch, 2 * LAP + 2, np, pos);
            check($sformatf("R4 disabled ch%0d v%0d", ch, v), np, 0);
         end
      // R4: cancel an armed match
      do_reset();
      write(0, 5'd6); write(0, 5'h16);
      watch(0, 2 * LAP + 2, np, pos);
      check("R4 cancel", np, 0);

      // R7: halted hypervisor match dropped until next lap
      do_reset();
      write(1, 5'd5);
      thread_halted = 1'b1;
      watch(1, 6, np, pos);
      check("R7 halted drop", np, 0);
      thread_halted = 1'b0;
      watch(1, 15, np, pos);
      check("R7 stays disarmed", np, 0);
      watch(1, 1, np, pos);
      check("R7 next lap", np, 1);
      // R7: supervisor unaffected by halt
      do_reset();
      thread_halted = 1'b1;
      write(0, 5'd3);
      watch(0, 4, np, pos);
      check("R7 sup ignores halt", pos, 4);
      thread_halted = 1'b0;

      // R8: write in the match cycle wins
      do_reset();
      write(0, 5'd3);
      ticks(3);
      check("R8 at value", count, 3);
      write(0, 5'd8);
      check("R8 no old req", soft_tick_req, 0);
      watch(0, 6, np, pos);
      check("R8 new position", pos, 6);
      check("R8 new count", np, 1);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done) begin
         done = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule